// File: doc/BRIEF.md
# UART Receive Status Flag Controller

This block sits between a UART receiver's bit sampler and the bus. Each time the receiver finishes a frame, it pulses a strobe. With the strobe it supplies the received data word, the sampled stop bit, and a parity sum. The block decides whether the frame is stored, whether it is an overrun, and whether it carries a framing or parity error. It keeps four flags in a status word, holds the most recent accepted data word, and tells the receiver to stop delivering frames while a framing error is pending.

Software clears the flags in two steps. First it reads the status word, which arms the flags that are set at that moment. A later read of the data word then clears only the armed flags. A flag that sets between the two reads survives the data read. It must be cleared by a fresh sequence.

Top module: `uart_rx_flags`

## Requirements
- R1: A stored frame whose sampled stop bit is 0 sets the framing flag (status bit 2).
- R2: The parity flag (status bit 3) sets on a stored frame only when parity checking is enabled and the parity sum does not match the selected type. The parity sum is the XOR of the data bits and the received parity bit. Even type (par_odd=0) expects a sum of 0, and odd type (par_odd=1) expects 1. With checking disabled, the flag stays 0.
- R3: The framing and parity flags become 1 in the same clock cycle as the data-full flag (status bit 0).
- R4: A frame that causes an overrun never sets the framing or parity flag.
- R5: While the framing flag is 1, rx_inhibit is 1. Completed frames are then ignored: the data word and the flags are unchanged.
- R6: A status read followed by a data read clears every flag that was 1 at the status read.
- R7: A data read with no preceding status read clears no flag.
- R8: A frame that completes while the data-full flag is 1 sets the overrun flag (status bit 1) and leaves the stored data word unchanged.
- R9: A flag that sets after the status read is not cleared by the following data read.
- R10: After reset, all flags, the data word and rx_inhibit are 0.
- R11: A frame with no errors, arriving while the data-full flag is 0, stores its data word and sets only the data-full flag. Both are visible one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle strobe: a frame has been received |
| frame_data | input | DATA_W | Received data word |
| stop_bit | input | 1 | Sampled stop bit level |
| par_sum | input | 1 | XOR of the data bits and the received parity bit |
| par_en | input | 1 | Parity checking enable |
| par_odd | input | 1 | Parity type: 0 even, 1 odd |
| stat_rd | input | 1 | Bus read strobe of the status word |
| data_rd | input | 1 | Bus read strobe of the data word |
| status | output | 4 | Flags: bit0 data-full, bit1 overrun, bit2 framing, bit3 parity |
| rx_data | output | DATA_W | Stored data word |
| rx_inhibit | output | 1 | Tells the receiver to deliver no frames |

## Verification
The bench builds the block with its default DATA_W of 8. This lets full bytes with alternating bit patterns show whether a data word was captured, was kept on an overrun, or was blocked by the inhibit. The parity sum is driven directly rather than derived from the data. This makes every combination of enable, type and sum reachable without building a transmitter. Overrun and late-flag cases are reached by interleaving frames between the status and data reads.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
  localparam int ST_W    = 4;
  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_FE   = 2;
  localparam int ST_PE   = 3;

  // Parity mismatch: the sum must equal the selected type bit.
  function automatic logic parity_bad(logic en, logic odd, logic sum);
    return en & (sum ^ odd);
  endfunction
endpackage

// File: rtl/rxf_frame_eval.sv
module rxf_frame_eval
  import uart_rxf_pkg::*;
(
  input  logic frame_done,
  input  logic inhibit,
  input  logic full_eff,
  input  logic stop_bit,
  input  logic par_en,
  input  logic par_odd,
  input  logic par_sum,
  output logic load_evt,
  output logic ovr_evt,
  output logic fe_evt,
  output logic pe_evt
);
  logic accept;

  always_comb begin
    accept   = frame_done & ~inhibit;
    ovr_evt  = accept & full_eff;
    load_evt = accept & ~full_eff;
    fe_evt   = load_evt & ~stop_bit;
    pe_evt   = load_evt & parity_bad(par_en, par_odd, par_sum);
  end
endmodule

// File: rtl/rxf_flag_cell.sv
module rxf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set_i | (q & ~clr_i);
  end
endmodule

// File: rtl/rxf_clear_arm.sv
module rxf_clear_arm
  import uart_rxf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_rd,
  input  logic            data_rd,
  input  logic [ST_W-1:0] flags,
  output logic [ST_W-1:0] clr_vec
);
  logic [ST_W-1:0] arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm_q <= '0;
    else if (stat_rd) arm_q <= flags;
    else if (data_rd) arm_q <= '0;
  end

  assign clr_vec = data_rd ? arm_q : '0;

  // R7: a data read with nothing armed clears nothing
  assert_no_arm_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && arm_q == '0) |-> clr_vec == '0);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rxf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              stop_bit,
  input  logic              par_sum,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [ST_W-1:0]   status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_inhibit
);
  logic [ST_W-1:0] flags;
  logic [ST_W-1:0] clr_vec;
  logic [ST_W-1:0] set_vec;
  logic            full_eff;
  logic            load_evt, ovr_evt, fe_evt, pe_evt;

  assign rx_inhibit = flags[ST_FE];
  assign full_eff   = flags[ST_FULL] & ~clr_vec[ST_FULL];

  rxf_frame_eval u_eval (
    .frame_done (frame_done),
    .inhibit    (rx_inhibit),
    .full_eff   (full_eff),
    .stop_bit   (stop_bit),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .par_sum    (par_sum),
    .load_evt   (load_evt),
    .ovr_evt    (ovr_evt),
    .fe_evt     (fe_evt),
    .pe_evt     (pe_evt)
  );

  rxf_clear_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (stat_rd),
    .data_rd (data_rd),
    .flags   (flags),
    .clr_vec (clr_vec)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_FULL] = load_evt;
    set_vec[ST_OVR]  = ovr_evt;
    set_vec[ST_FE]   = fe_evt;
    set_vec[ST_PE]   = pe_evt;
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_flag
    rxf_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q     (flags[i])
    );

    // R6: a flag only falls as the result of a data read
    assert_fall_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(data_rd));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_data <= '0;
    else if (load_evt) rx_data <= frame_data;
  end

  assign status = flags;

  assert_fe_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[ST_FE]) |-> !$past(stop_bit));
  assert_pe_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[ST_PE]) |-> $past(par_en));
  assert_fe_with_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[ST_FE]) |-> flags[ST_FULL]);
  assert_pe_with_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[ST_PE]) |-> flags[ST_FULL]);
  assert_no_err_on_ovr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[ST_OVR]) |-> !$rose(flags[ST_FE]) && !$rose(flags[ST_PE]));
  assert_inhibit_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_inhibit && frame_done) |=> $stable(rx_data));
  assert_keep_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && flags[ST_FULL] && !data_rd) |=> $stable(rx_data));
endmodule

// File: tb/uart_rx_flags_tb.sv
`timescale 1ns/1ps
module uart_rx_flags_tb;
  logic       clk = 0, rst_n = 0;
  logic       frame_done = 0, stop_bit = 1, par_sum = 0, par_en = 0, par_odd = 0;
  logic       stat_rd = 0, data_rd = 0;
  logic [7:0] frame_data = 0;
  logic [3:0] status;
  logic [7:0] rx_data;
  logic       rx_inhibit;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  uart_rx_flags #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .stop_bit(stop_bit), .par_sum(par_sum), .par_en(par_en), .par_odd(par_odd),
    .stat_rd(stat_rd), .data_rd(data_rd), .status(status), .rx_data(rx_data),
    .rx_inhibit(rx_inhibit));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic stp, logic ps);
    @(negedge clk);
    frame_data = d; stop_bit = stp; par_sum = ps; frame_done = 1;
    @(negedge clk);
    frame_done = 0; stop_bit = 1;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic rd_data();
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  task automatic clear_all();
    rd_stat(); rd_data();
  endtask

  task automatic t_reset();
    chk("R10 status", status, 0);
    chk("R10 data", rx_data, 0);
    chk("R10 inhibit", rx_inhibit, 0);
  endtask

  task automatic t_good();
    par_en = 0;
    send(8'hA5, 1, 0);
    chk("R11 status", status, 4'b0001);
    chk("R11 data", rx_data, 8'hA5);
    clear_all();
    chk("R6 cleared", status, 0);
  endtask

  task automatic t_parity();
    par_en = 1; par_odd = 0;
    send(8'h5A, 1, 1);
    chk("R2 even mismatch", status, 4'b1001);
    chk("R3 pe with full", status[3] & status[0], 1);
    clear_all();
    par_odd = 1;
    send(8'h0F, 1, 1);
    chk("R2 odd match", status, 4'b0001);
    clear_all();
    par_en = 0;
    send(8'hF0, 1, 0);
    chk("R2 disabled", status, 4'b0001);
    clear_all(); par_odd = 0;
  endtask

  task automatic t_framing();
    send(8'hC3, 0, 0);
    chk("R1 framing", status, 4'b0101);
    chk("R3 fe with full", status[2] & status[0], 1);
    chk("R5 inhibit", rx_inhibit, 1);
    send(8'h3C, 1, 0);
    chk("R5 data held", rx_data, 8'hC3);
    chk("R5 flags held", status, 4'b0101);
    clear_all();
    chk("R6 fe cleared", status, 0);
    chk("R5 inhibit off", rx_inhibit, 0);
  endtask

  task automatic t_overrun();
    par_en = 1; par_odd = 0;
    send(8'h11, 1, 0);
    send(8'h22, 0, 1);
    chk("R8 ovr set", status[1], 1);
    chk("R4 no fe pe", status, 4'b0011);
    chk("R8 old data", rx_data, 8'h11);
    clear_all(); par_en = 0;
    chk("R6 ovr cleared", status, 0);
  endtask

  task automatic t_data_only();
    send(8'h77, 1, 0);
    rd_data();
    chk("R7 no clear", status, 4'b0001);
    clear_all();
  endtask

  task automatic t_late();
    send(8'h44, 1, 0);
    rd_stat();
    send(8'h55, 1, 0);
    rd_data();
    chk("R9 ovr survives", status, 4'b0010);
    chk("R9 data", rx_data, 8'h44);
    clear_all();
    chk("R9 second clear", status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_good(); t_parity(); t_framing(); t_overrun(); t_data_only(); t_late();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule